// File: doc/BRIEF.md
# Logic Analyzer Trigger and Capture Controller

This block is the acquisition engine of an on-chip logic analyzer. A set of equal-width probes is sampled every clock. A trigger unit judges each probe against its own programmed condition and merges the per-probe results through one gate, which can be set to AND or to OR. A capture state machine streams the samples into a circular buffer. The engine keeps a chosen number of samples from before the trigger, and after the trigger it fills the rest of the buffer.

A build-time parameter can replace the per-probe logic with an external trigger input. Software sees the block through a small register port. Over that port it sets the pre-trigger count and the probe conditions, issues a start, and polls the state. When the capture is done, it reads the oldest-sample index and then walks the buffer from that index to get the samples in time order.

Top module: `la_capture`

## Requirements
- R1: After reset, the state code reads 0 (idle), the pre-trigger count reads 0, the combine mode reads 0 (AND), the oldest-sample index reads 0, and every probe condition is off.
- R2: Register map (address bit 7 clear): 0 = control/state (a write with bit 0 set is a start; a read gives the state code: idle 0, filling 1, armed 2, post-trigger 3, done 4); 1 = pre-trigger count; 2 = combine mode in bit 0 (0 AND, 1 OR); 3 = oldest-sample index (read only); 4+2p = condition code of probe p; 5+2p = argument of probe p. An address with bit 7 set reads buffer entry addr[IW-1:0]. `reg_rdata` shows, one cycle later, the value at the address presented in the cycle before.
- R3: Writing a pre-trigger count above DEPTH-1 stores DEPTH-1.
- R4: A start is taken only in idle or done. It moves to filling, or straight to armed when the count is 0, and it resets the write index to 0. A start in filling, armed or post-trigger is ignored.
- R5: Each cycle spent in filling, armed or post-trigger stores one sample at the next circular index, beginning at 0. Probe p sits at bits [p*PW +: PW] of the sample. No sample is stored in idle or done.
- R6: Filling lasts exactly as many samples as the pre-trigger count latched at start, and the trigger is ignored during it.
- R7: Probe condition codes: 0 off; 1 equal to the argument; 2 not equal; 3 rise (some bit set in the argument went 0 to 1 since the previous cycle's probe value); 4 fall (masked 1 to 0); 5 change (masked bit differs); 6 and 7 off. The previous value is the probe's value one cycle earlier, whatever the state.
- R8: In AND mode the trigger needs every enabled probe to hit. In OR mode any enabled probe that hits is enough. With no probe enabled, the trigger never fires.
- R9: In armed, the sample taken in the trigger cycle is stored as the first of DEPTH minus count post-trigger samples, and the state then becomes done.
- R10: In done, the oldest-sample index is where the oldest kept sample lies. Reading DEPTH entries upward from it, with wrap-around, gives consecutive samples in time order, and the trigger sample is at offset equal to the count.
- R11: Done holds with no writes until a start, and that start begins a fresh capture.
- R12: With EXT_TRIG set to 1, the `ext_trig` input is the trigger, and the probe conditions and combine mode have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probes | input | NPROBE*PW | Probe samples, probe p at [p*PW +: PW] |
| ext_trig | input | 1 | External trigger, used only when EXT_TRIG = 1 |
| reg_addr | input | AW | Register / buffer address |
| reg_wdata | input | DW | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | DW | Registered read data |

## Verification
The bench targets several corners, and each has a typical bad result:
- A pre-trigger count of 0 or DEPTH-1. An off-by-one there shifts the trigger sample away from its offset or writes one sample too many past the wanted window.
- A matching sample placed inside the filling phase. A design that watches the trigger too early would start capturing there instead of staying armed.
- A start issued while filling or armed. A design that accepts it would restart, and the state read back would drop to filling.
- The external-trigger build, with a probe condition that would fire at once. A design that leaks the probe path would capture at the wrong cycle and report a different oldest index.

// File: rtl/la_capture_pkg.sv
package la_capture_pkg;

  typedef enum logic [2:0] {
    CS_IDLE  = 3'd0,
    CS_FILL  = 3'd1,
    CS_ARMED = 3'd2,
    CS_POST  = 3'd3,
    CS_DONE  = 3'd4
  } cap_state_t;

  localparam int OPW = 3;

  localparam logic [OPW-1:0] OP_OFF  = 3'd0;
  localparam logic [OPW-1:0] OP_EQ   = 3'd1;
  localparam logic [OPW-1:0] OP_NE   = 3'd2;
  localparam logic [OPW-1:0] OP_RISE = 3'd3;
  localparam logic [OPW-1:0] OP_FALL = 3'd4;
  localparam logic [OPW-1:0] OP_CHG  = 3'd5;

  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_PRECNT = 1;
  localparam int ADDR_MODE   = 2;
  localparam int ADDR_OLDEST = 3;
  localparam int ADDR_PROBE0 = 4;

endpackage

// File: rtl/la_probe_trig.sv
module la_probe_trig
  import la_capture_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PW-1:0]  cur,
  input  logic [OPW-1:0] op,
  input  logic [PW-1:0]  arg,
  output logic           hit,
  output logic           en
);

  logic [PW-1:0] prev;

  function automatic logic eval_op(input logic [OPW-1:0] o, input logic [PW-1:0] c,
                                   input logic [PW-1:0] p, input logic [PW-1:0] a);
    case (o)
      OP_EQ:   return c == a;
      OP_NE:   return c != a;
      OP_RISE: return |(~p & c & a);
      OP_FALL: return |(p & ~c & a);
      OP_CHG:  return |((p ^ c) & a);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_active(input logic [OPW-1:0] o);
    return (o >= OP_EQ) && (o <= OP_CHG);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= cur;
  end

  assign hit = eval_op(op, cur, prev, arg);
  assign en  = op_active(op);

endmodule

// File: rtl/la_trig_unit.sv
module la_trig_unit
  import la_capture_pkg::*;
#(
  parameter int NPROBE   = 2,
  parameter int PW       = 8,
  parameter bit EXT_TRIG = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPROBE*PW-1:0]  probes,
  input  logic [NPROBE*OPW-1:0] ops,
  input  logic [NPROBE*PW-1:0]  args,
  input  logic                  combine_or,
  input  logic                  ext_trig,
  output logic                  trig
);

  generate
    if (EXT_TRIG) begin : g_ext
      assign trig = ext_trig;
      logic unused_cfg;
      assign unused_cfg = ^{probes, ops, args, combine_or, clk, rst_n};
    end else begin : g_int
      logic [NPROBE-1:0] hits;
      logic [NPROBE-1:0] ens;
      for (genvar p = 0; p < NPROBE; p++) begin : g_probe
        la_probe_trig #(.PW(PW)) u_probe (
          .clk (clk),
          .rst_n (rst_n),
          .cur (probes[p*PW +: PW]),
          .op  (ops[p*OPW +: OPW]),
          .arg (args[p*PW +: PW]),
          .hit (hits[p]),
          .en  (ens[p])
        );
      end
      assign trig = (|ens) && (combine_or ? |(hits & ens) : &(hits | ~ens));
      logic unused_ext;
      assign unused_ext = ext_trig;
    end
  endgenerate

endmodule

// File: rtl/la_capture_fsm.sv
module la_capture_fsm
  import la_capture_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_cmd,
  input  logic [IW-1:0] precnt,
  input  logic          trig,
  output cap_state_t    state,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [IW-1:0] tp_run,
  output logic [IW-1:0] oldest
);

  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [IW-1:0] filled;
  logic [IW-1:0] rem;
  logic          start_ok;

  assign start_ok = start_cmd && (state == CS_IDLE || state == CS_DONE);
  assign wr_en    = (state == CS_FILL) || (state == CS_ARMED) || (state == CS_POST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= CS_IDLE;
      wr_idx <= '0;
      filled <= '0;
      rem    <= '0;
      tp_run <= '0;
      oldest <= '0;
    end else if (start_ok) begin
      state  <= (precnt == '0) ? CS_ARMED : CS_FILL;
      wr_idx <= '0;
      filled <= '0;
      tp_run <= precnt;
    end else begin
      if (wr_en) wr_idx <= wr_idx + 1'b1;
      case (state)
        CS_FILL: begin
          filled <= filled + 1'b1;
          if (filled + 1'b1 == tp_run) state <= CS_ARMED;
        end
        CS_ARMED: begin
          if (trig) begin
            if (tp_run == LAST) begin
              state  <= CS_DONE;
              oldest <= wr_idx + 1'b1;
            end else begin
              state <= CS_POST;
              rem   <= LAST - tp_run;
            end
          end
        end
        CS_POST: begin
          rem <= rem - 1'b1;
          if (rem == IW'(1)) begin
            state  <= CS_DONE;
            oldest <= wr_idx + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/la_sample_mem.sv
module la_sample_mem #(
  parameter int DEPTH = 16,
  parameter int SW    = 16,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [SW-1:0] wdata,
  input  logic [IW-1:0] rd_idx,
  output logic [SW-1:0] rdata
);

  logic [SW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wdata;
  end

  assign rdata = mem[rd_idx];

endmodule

// File: rtl/la_ctrl_regs.sv
module la_ctrl_regs
  import la_capture_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int NPROBE = 2,
  parameter int PW     = 8,
  parameter int DEPTH  = 16,
  parameter int IW     = $clog2(DEPTH),
  parameter int SW     = NPROBE * PW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         reg_addr,
  input  logic [DW-1:0]         reg_wdata,
  input  logic                  reg_we,
  input  cap_state_t            state,
  input  logic [IW-1:0]         oldest,
  input  logic [SW-1:0]         mem_rdata,
  output logic [IW-1:0]         precnt,
  output logic                  combine_or,
  output logic [NPROBE*OPW-1:0] ops,
  output logic [NPROBE*PW-1:0]  args,
  output logic                  start_cmd,
  output logic [IW-1:0]         mem_raddr,
  output logic [DW-1:0]         reg_rdata
);

  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [DW-1:0] rd_next;

  function automatic logic [IW-1:0] clamp_cnt(input logic [DW-1:0] v);
    if (v > DW'(DEPTH - 1)) return LAST;
    return v[IW-1:0];
  endfunction

  assign start_cmd = reg_we && (reg_addr == AW'(ADDR_CTRL)) && reg_wdata[0];
  assign mem_raddr = reg_addr[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      precnt     <= '0;
      combine_or <= 1'b0;
      ops        <= '0;
      args       <= '0;
    end else if (reg_we) begin
      if (reg_addr == AW'(ADDR_PRECNT)) precnt <= clamp_cnt(reg_wdata);
      if (reg_addr == AW'(ADDR_MODE))   combine_or <= reg_wdata[0];
      for (int p = 0; p < NPROBE; p++) begin
        if (reg_addr == AW'(ADDR_PROBE0 + 2*p))     ops[p*OPW +: OPW] <= reg_wdata[OPW-1:0];
        if (reg_addr == AW'(ADDR_PROBE0 + 2*p + 1)) args[p*PW +: PW]  <= reg_wdata[PW-1:0];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (reg_addr[AW-1]) begin
      rd_next = DW'(mem_rdata);
    end else begin
      if (reg_addr == AW'(ADDR_CTRL))   rd_next = DW'(state);
      if (reg_addr == AW'(ADDR_PRECNT)) rd_next = DW'(precnt);
      if (reg_addr == AW'(ADDR_MODE))   rd_next = DW'(combine_or);
      if (reg_addr == AW'(ADDR_OLDEST)) rd_next = DW'(oldest);
      for (int p = 0; p < NPROBE; p++) begin
        if (reg_addr == AW'(ADDR_PROBE0 + 2*p))     rd_next = DW'(ops[p*OPW +: OPW]);
        if (reg_addr == AW'(ADDR_PROBE0 + 2*p + 1)) rd_next = DW'(args[p*PW +: PW]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_next;
  end

endmodule

// File: rtl/la_capture.sv
module la_capture
  import la_capture_pkg::*;
#(
  parameter int NPROBE   = 2,
  parameter int PW       = 8,
  parameter int DEPTH    = 16,
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter bit EXT_TRIG = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPROBE*PW-1:0] probes,
  input  logic                 ext_trig,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  input  logic                 reg_we,
  output logic [DW-1:0]        reg_rdata
);

  localparam int IW = $clog2(DEPTH);
  localparam int SW = NPROBE * PW;

  cap_state_t            cap_state;
  logic                  start_cmd;
  logic                  trig_fire;
  logic                  wr_en;
  logic [IW-1:0]         wr_idx;
  logic [IW-1:0]         tp_run;
  logic [IW-1:0]         oldest_idx;
  logic [IW-1:0]         precnt;
  logic                  combine_or;
  logic [NPROBE*OPW-1:0] ops;
  logic [NPROBE*PW-1:0]  args;
  logic [IW-1:0]         mem_raddr;
  logic [SW-1:0]         mem_rdata;

  la_ctrl_regs #(.AW(AW), .DW(DW), .NPROBE(NPROBE), .PW(PW), .DEPTH(DEPTH)) u_regs (
    .clk (clk), .rst_n (rst_n),
    .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_we (reg_we),
    .state (cap_state), .oldest (oldest_idx), .mem_rdata (mem_rdata),
    .precnt (precnt), .combine_or (combine_or), .ops (ops), .args (args),
    .start_cmd (start_cmd), .mem_raddr (mem_raddr), .reg_rdata (reg_rdata)
  );

  la_trig_unit #(.NPROBE(NPROBE), .PW(PW), .EXT_TRIG(EXT_TRIG)) u_trig (
    .clk (clk), .rst_n (rst_n), .probes (probes), .ops (ops), .args (args),
    .combine_or (combine_or), .ext_trig (ext_trig), .trig (trig_fire)
  );

  la_capture_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk (clk), .rst_n (rst_n), .start_cmd (start_cmd), .precnt (precnt),
    .trig (trig_fire), .state (cap_state), .wr_en (wr_en), .wr_idx (wr_idx),
    .tp_run (tp_run), .oldest (oldest_idx)
  );

  la_sample_mem #(.DEPTH(DEPTH), .SW(SW)) u_mem (
    .clk (clk), .wr_en (wr_en), .wr_idx (wr_idx), .wdata (probes),
    .rd_idx (mem_raddr), .rdata (mem_rdata)
  );

endmodule

// File: rtl/la_capture_chk.sv
module la_capture_chk
  import la_capture_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_cmd,
  input logic          trig_fire,
  input cap_state_t    state,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic [IW-1:0] tp_run
);

  logic [IW:0] post_cnt;
  logic        start_ok;
  logic        post_wr;

  assign start_ok = start_cmd && (state == CS_IDLE || state == CS_DONE);
  assign post_wr  = wr_en && (state == CS_POST || (state == CS_ARMED && trig_fire));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        post_cnt <= '0;
    else if (start_ok) post_cnt <= '0;
    else if (post_wr)  post_cnt <= post_cnt + 1'b1;
  end

  a_r5_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CS_IDLE || state == CS_DONE) |-> !wr_en);

  a_r5_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wr_idx == IW'($past(wr_idx) + 1'b1));

  a_r4_fill_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && state == CS_FILL) |=> (state == CS_FILL || state == CS_ARMED));

  a_r4_armed_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && state == CS_ARMED && !trig_fire) |=> state == CS_ARMED);

  a_r6_fill_ignores_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    state == CS_FILL |=> (state == CS_FILL || state == CS_ARMED));

  a_r9_armed_leaves_on_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CS_ARMED && trig_fire) |=> (state == CS_POST || state == CS_DONE));

  a_r9_post_window_length: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CS_DONE && $past(state) != CS_DONE) |-> post_cnt == (IW+1)'(DEPTH) - (IW+1)'(tp_run));

  a_r11_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CS_DONE && !start_cmd) |=> state == CS_DONE);

  a_r11_restart_from_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CS_DONE && start_cmd) |=> (state == CS_FILL || state == CS_ARMED));

endmodule

bind la_capture la_capture_chk #(.DEPTH(DEPTH)) u_chk (
  .clk (clk), .rst_n (rst_n), .start_cmd (start_cmd), .trig_fire (trig_fire),
  .state (cap_state), .wr_en (wr_en), .wr_idx (wr_idx), .tp_run (tp_run)
);

// File: tb/la_capture_tb.sv
`timescale 1ns/1ps
module la_capture_tb;

  localparam int SEQ = 48;
  localparam int DEP = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] probes = '0;
  logic        ext_trig = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we0 = 1'b0, we1 = 1'b0;
  logic [15:0] rd0, rd1;

  int n_cmp = 0, n_bad = 0;
  int seq [SEQ];
  int pre;
  int cfg_op [2];
  int cfg_arg [2];
  bit cfg_or;
  int cfg_tp;
  bit use_ext;
  int ext_at;

  always #4 clk = ~clk;

  la_capture u_dut (
    .clk (clk), .rst_n (rst_n), .probes (probes), .ext_trig (ext_trig),
    .reg_addr (addr), .reg_wdata (wdata), .reg_we (we0), .reg_rdata (rd0)
  );

  la_capture #(.EXT_TRIG(1'b1)) u_dut_ext (
    .clk (clk), .rst_n (rst_n), .probes (probes), .ext_trig (ext_trig),
    .reg_addr (addr), .reg_wdata (wdata), .reg_we (we1), .reg_rdata (rd1)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input int a, input int d);
    addr = 8'(a); wdata = 16'(d);
    if (sel) we1 = 1'b1; else we0 = 1'b1;
    @(posedge clk); @(negedge clk);
    we0 = 1'b0; we1 = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input bit sel, input int a, output int v);
    addr = 8'(a);
    @(posedge clk); @(negedge clk);
    v = sel ? int'(rd1) : int'(rd0);
    addr = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; we0 = 1'b0; we1 = 1'b0; addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic bit m_hit(int op, int c, int p, int a);
    case (op)
      1: return c == a;
      2: return c != a;
      3: return ((c & ~p) & a & 255) != 0;
      4: return ((p & ~c) & a & 255) != 0;
      5: return ((p ^ c) & a & 255) != 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit m_trig(int i);
    int prv, n_en, n_hit;
    if (use_ext) return i == ext_at;
    prv = (i == 0) ? pre : seq[i-1];
    n_en = 0; n_hit = 0;
    for (int p = 0; p < 2; p++) begin
      if (cfg_op[p] >= 1 && cfg_op[p] <= 5) begin
        n_en++;
        if (m_hit(cfg_op[p], (seq[i] >> (8*p)) & 255, (prv >> (8*p)) & 255, cfg_arg[p])) n_hit++;
      end
    end
    if (n_en == 0) return 1'b0;
    return cfg_or ? (n_hit > 0) : (n_hit == n_en);
  endfunction

  // Runs one capture on the selected instance; returns the model's final state code.
  task automatic run_capture(input bit sel, input string tag, output int fin);
    int tp, st, filled, rem, j, v, oe;
    tp = (cfg_tp > DEP-1) ? DEP-1 : cfg_tp;
    probes = 16'(pre);
    wr(sel, 1, cfg_tp);
    wr(sel, 2, int'(cfg_or));
    for (int p = 0; p < 2; p++) begin
      wr(sel, 4 + 2*p, cfg_op[p]);
      wr(sel, 5 + 2*p, cfg_arg[p]);
    end
    st = (tp == 0) ? 2 : 1; filled = 0; rem = 0; j = -1;
    for (int i = 0; i < SEQ; i++) begin
      if (st == 1) begin
        filled++;
        if (filled == tp) st = 2;
      end else if (st == 2) begin
        if (m_trig(i)) begin
          j = i;
          if (tp == DEP-1) st = 4; else begin st = 3; rem = DEP-1-tp; end
        end
      end else if (st == 3) begin
        rem--;
        if (rem == 0) st = 4;
      end
    end
    wr(sel, 0, 1);
    for (int i = 0; i < SEQ; i++) begin
      probes = 16'(seq[i]);
      ext_trig = use_ext && (i == ext_at);
      @(posedge clk); @(negedge clk);
    end
    ext_trig = 1'b0;
    rd(sel, 0, v);
    chk(tag, v, st);
    if (st == 4) begin
      oe = (j + DEP - tp) % DEP;
      rd(sel, 3, v);
      chk("R10 oldest index", v, oe);
      for (int k = 0; k < DEP; k++) begin
        rd(sel, 128 + ((oe + k) % DEP), v);
        chk("R5 R10 buffer order", v, seq[j - tp + k]);
      end
    end
    fin = st;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int v, fin;
    void'($urandom(32'd20240611));
    do_reset();

    // R1 reset values
    rd(0, 0, v); chk("R1 state", v, 0);
    rd(0, 1, v); chk("R1 precount", v, 0);
    rd(0, 2, v); chk("R1 mode", v, 0);
    rd(0, 3, v); chk("R1 oldest", v, 0);
    rd(0, 4, v); chk("R1 probe0 op", v, 0);

    // R2 readback and R3 clamp
    wr(0, 5, 8'hAB); rd(0, 5, v); chk("R2 arg readback", v, 8'hAB);
    wr(0, 6, 3);     rd(0, 6, v); chk("R2 op readback", v, 3);
    wr(0, 1, 200);   rd(0, 1, v); chk("R3 clamp", v, DEP-1);
    wr(0, 1, 16);    rd(0, 1, v); chk("R3 clamp edge", v, DEP-1);
    wr(0, 1, 7);     rd(0, 1, v); chk("R3 in range", v, 7);

    // R6: match only inside filling, must stay armed; then R4 start ignored in armed
    for (int i = 0; i < SEQ; i++) seq[i] = 16'hA500 | i;
    pre = 16'hA5FF; cfg_tp = 4; cfg_or = 0; use_ext = 0;
    cfg_op[0] = 1; cfg_arg[0] = 1; cfg_op[1] = 0; cfg_arg[1] = 0;
    run_capture(0, "R6 trigger ignored while filling", fin);
    wr(0, 0, 1);
    rd(0, 0, v); chk("R4 start ignored when armed", v, 2);
    do_reset();

    // R4: start during filling ignored
    wr(0, 1, 10);
    wr(0, 0, 1);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    wr(0, 0, 1);
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk("R4 start ignored when filling", int'(rd0), 2);
    do_reset();

    // R8: AND needs both probes in one cycle
    for (int i = 0; i < SEQ; i++) seq[i] = 16'h1111;
    seq[7] = 16'h1133; seq[9] = 16'h4411; seq[12] = 16'h4433;
    pre = 16'h1111; cfg_tp = 3; cfg_or = 0;
    cfg_op[0] = 1; cfg_arg[0] = 8'h33; cfg_op[1] = 1; cfg_arg[1] = 8'h44;
    run_capture(0, "R8 AND combine", fin);

    // R7 R9: count 0 with rise, then DEPTH-1 with change in OR mode
    for (int i = 0; i < SEQ; i++) seq[i] = int'($urandom & 16'hFFFF);
    pre = 0; cfg_tp = 0; cfg_or = 1;
    cfg_op[0] = 3; cfg_arg[0] = 8'h80; cfg_op[1] = 0;
    run_capture(0, "R7 R9 count zero", fin);
    if (fin != 4) do_reset();
    for (int i = 0; i < SEQ; i++) seq[i] = int'($urandom & 16'hFFFF);
    cfg_tp = 15; cfg_op[0] = 0; cfg_op[1] = 5; cfg_arg[1] = 8'h0F;
    run_capture(0, "R9 R11 count max restart", fin);
    if (fin != 4) do_reset();

    // R8: no enabled probe never triggers
    cfg_tp = 2; cfg_op[0] = 6; cfg_op[1] = 0;
    run_capture(0, "R8 nothing enabled", fin);
    do_reset();

    // R12: external trigger build ignores probe conditions
    for (int i = 0; i < SEQ; i++) seq[i] = int'($urandom & 16'hFFFF);
    pre = 0; cfg_tp = 2; cfg_or = 1; use_ext = 1; ext_at = 5;
    cfg_op[0] = 5; cfg_arg[0] = 8'hFF; cfg_op[1] = 2; cfg_arg[1] = 0;
    run_capture(1, "R12 external trigger", fin);
    use_ext = 0;
    do_reset();

    // Random captures: R7 R8 R9 R10 R11
    for (int it = 0; it < 16; it++) begin
      for (int i = 0; i < SEQ; i++) seq[i] = int'($urandom & 16'hFFFF);
      pre = int'($urandom & 16'hFFFF);
      cfg_tp = int'($urandom % 20);
      cfg_or = 1'($urandom);
      for (int p = 0; p < 2; p++) begin
        cfg_op[p] = int'($urandom % 8);
        if (cfg_op[p] == 1) cfg_arg[p] = (seq[20 + int'($urandom % 20)] >> (8*p)) & 255;
        else                cfg_arg[p] = int'($urandom & 255);
      end
      run_capture(0, "R7 R8 R11 random capture state", fin);
      if (fin != 4) do_reset();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule